// File: doc/BRIEF.md
# Open-Row-First DRAM Request Scheduler

This block holds a small queue of read and write requests aimed at a single DRAM bank and decides, one command at a time, what the bank does next. It remembers whether a row is latched in the bank's row buffer and which row that is. A request whose row is already latched only needs a column command, while any other request costs a precharge and an activate first. Because loading a row takes a fixed, sizeable number of cycles, the scheduler serves pending requests to the latched row ahead of older requests to other rows.

When nothing in the queue matches the latched row, the oldest request is chosen. The bank is precharged if needed, and then that request's row is activated. A per-entry count of how often a request has been passed over stops a stream of row hits from starving an older request. A refresh request closes the bank and then issues a refresh of a given row. That row then counts as latched.

Requests enter through a valid/ready interface. Commands leave through a valid/ready command port that carries an opcode, a row, a column and the request tag. After each activate, precharge or refresh the port stays quiet for a fixed number of cycles.

Top module: `rowfirst_sched`

## Requirements
- R1: After reset cmd_valid is low, req_ready is high and no row is latched, so the first request produces an activate (opcode 1) with no precharge before it.
- R2: req_ready is low exactly while DEPTH requests are pending and high otherwise.
- R3: A read or write is issued only to the latched row. A request to a closed bank gets an activate carrying its row, then a column command (read opcode 3, write opcode 4) carrying its row, column and tag.
- R4: While the latched row is open, the oldest pending request that targets it is issued before any pending request to another row, even an older one.
- R5: When no pending request targets the latched row, the oldest pending request is chosen. The scheduler issues a precharge (opcode 2) if a row is open, then an activate of that request's row, and an activate or refresh is never issued while a row is open.
- R6: A write and a later read to the same row and column are issued in arrival order.
- R7: A request that has been passed over AGE_CAP times by younger column commands is served next. Its row is precharged and activated even while requests to the latched row are pending.
- R8: When rfsh_req is high at a decision point, refresh takes precedence over queued requests. An open row is precharged first, then a refresh (opcode 5) is issued with rfsh_row, and that row then counts as latched, so a request to it needs no activate.
- R9: While cmd_valid is high and cmd_ready low, cmd_valid, cmd_op, cmd_row, cmd_col and cmd_tag hold their values.
- R10: With cmd_ready high and work pending, the command after an accepted activate, precharge or refresh is accepted exactly ACT_CYC+2, PRE_CYC+2 or REF_CYC+2 cycles after it, and never sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The queue can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_tag | input | TAG_W | Tag returned with the column command |
| rfsh_req | input | 1 | Refresh wanted at the next decision point |
| rfsh_row | input | ROW_W | Row to refresh |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | The bank accepts the presented command |
| cmd_op | output | 3 | 1 activate, 2 precharge, 3 read, 4 write, 5 refresh |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of a read or write |
| cmd_tag | output | TAG_W | Tag of a read or write |

## Verification
The bench builds the scheduler with DEPTH 4, AGE_CAP 3, PRE_CYC 2, ACT_CYC 3 and REF_CYC 4. The shallow queue lets a handful of requests fill it, so the refused-enqueue state can be observed. The low age cap lets three row hits push an older miss to its forced turn while another hit is still queued. The short fixed gaps keep every command sequence short enough to check each opcode, row, tag and acceptance cycle exactly.

// File: rtl/rowfirst_pkg.sv
package rowfirst_pkg;

    // Command opcodes presented on the bank command port
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_PRE  = 3'd2,
        OP_RD   = 3'd3,
        OP_WR   = 3'd4,
        OP_REF  = 3'd5
    } dram_op_e;

endpackage

// File: rtl/rowfirst_hitpick.sv
// Lowest-index (oldest) set bit of a request vector
module rowfirst_hitpick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hit,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |hit;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rowfirst_queue.sv
// Age-ordered request queue: slot 0 is the oldest entry. Removal at any
// slot compacts the younger entries down; entries older than the removed
// one have their bypass count raised (saturating at AGE_CAP).
module rowfirst_queue #(
    parameter int DEPTH   = 8,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int TAG_W   = 4,
    parameter int AGE_CAP = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        push_wr,
    input  logic [ROW_W-1:0]            push_row,
    input  logic [COL_W-1:0]            push_col,
    input  logic [TAG_W-1:0]            push_tag,
    input  logic                        pop,
    input  logic [$clog2(DEPTH)-1:0]    pop_idx,
    output logic [$clog2(DEPTH+1)-1:0]  cnt,
    output logic [DEPTH-1:0]            ent_wr,
    output logic [ROW_W-1:0]            ent_row [DEPTH],
    output logic [COL_W-1:0]            ent_col [DEPTH],
    output logic [TAG_W-1:0]            ent_tag [DEPTH],
    output logic [$clog2(AGE_CAP+1)-1:0] byp_head
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AGE_W = $clog2(AGE_CAP + 1);

    typedef struct packed {
        logic             wr;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [TAG_W-1:0] tag;
        logic [AGE_W-1:0] byp;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t s_q, s_d;
    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        s_d = s_q;
        // removal and compaction
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && i >= int'(pop_idx)) begin
                s_d.ent[i] = (i < DEPTH - 1) ? s_q.ent[(i + 1) % DEPTH] : '0;
            end else if (pop && s_q.ent[i].byp < AGE_W'(AGE_CAP)) begin
                s_d.ent[i].byp = s_q.ent[i].byp + AGE_W'(1);
            end
        end
        cnt_after = s_q.cnt - CNT_W'(pop);
        // append behind the youngest remaining entry
        for (int i = 0; i < DEPTH; i++) begin
            if (push && CNT_W'(i) == cnt_after) begin
                s_d.ent[i] = '{wr: push_wr, row: push_row, col: push_col,
                               tag: push_tag, byp: '0};
            end
        end
        s_d.cnt = cnt_after + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign byp_head = s_q.ent[0].byp;

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign ent_wr[g]  = s_q.ent[g].wr;
        assign ent_row[g] = s_q.ent[g].row;
        assign ent_col[g] = s_q.ent[g].col;
        assign ent_tag[g] = s_q.ent[g].tag;
    end

endmodule

// File: rtl/rowfirst_sched.sv
module rowfirst_sched
    import rowfirst_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int TAG_W   = 4,
    parameter int AGE_CAP = 8,
    parameter int PRE_CYC = 3,
    parameter int ACT_CYC = 4,
    parameter int REF_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             rfsh_req,
    input  logic [ROW_W-1:0] rfsh_row,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic [TAG_W-1:0] cmd_tag
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int AGE_W   = $clog2(AGE_CAP + 1);
    localparam int TMR_MAX = (PRE_CYC > ACT_CYC) ?
                             ((PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC) :
                             ((ACT_CYC > REF_CYC) ? ACT_CYC : REF_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        logic             cmd_vld;
        dram_op_e         op;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic             row_open;
        logic [ROW_W-1:0] open_row;
        logic [TMR_W-1:0] timer;
    } sched_t;

    sched_t s_q, s_d;

    logic [CNT_W-1:0] q_cnt;
    logic [DEPTH-1:0] q_wr;
    logic [ROW_W-1:0] q_row [DEPTH];
    logic [COL_W-1:0] q_col [DEPTH];
    logic [TAG_W-1:0] q_tag [DEPTH];
    logic [AGE_W-1:0] q_byp0;
    logic             push, pop;
    logic [DEPTH-1:0] hit;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic             starved;
    logic [IDX_W-1:0] tgt;

    assign req_ready = (q_cnt < CNT_W'(DEPTH));
    assign push      = req_valid && req_ready;

    rowfirst_queue #(
        .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W),
        .TAG_W(TAG_W), .AGE_CAP(AGE_CAP)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_wr(req_write), .push_row(req_row),
        .push_col(req_col), .push_tag(req_tag),
        .pop(pop), .pop_idx(s_q.idx),
        .cnt(q_cnt), .ent_wr(q_wr), .ent_row(q_row), .ent_col(q_col),
        .ent_tag(q_tag), .byp_head(q_byp0)
    );

    // Entries that target the latched row
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = (CNT_W'(g) < q_cnt) && s_q.row_open &&
                        (q_row[g] == s_q.open_row);
    end

    rowfirst_hitpick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
        .hit(hit), .any(hit_any), .idx(hit_idx)
    );

    // The head is always the most-bypassed entry, so only it is checked
    assign starved = (q_cnt != '0) && (q_byp0 >= AGE_W'(AGE_CAP));
    assign tgt     = (starved || !hit_any) ? '0 : hit_idx;

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        if (s_q.cmd_vld) begin
            if (cmd_ready) begin
                s_d.cmd_vld = 1'b0;
                unique case (s_q.op)
                    OP_PRE: begin
                        s_d.row_open = 1'b0;
                        s_d.timer    = TMR_W'(PRE_CYC);
                    end
                    OP_ACT: begin
                        s_d.row_open = 1'b1;
                        s_d.open_row = s_q.row;
                        s_d.timer    = TMR_W'(ACT_CYC);
                    end
                    OP_REF: begin
                        s_d.row_open = 1'b1;
                        s_d.open_row = s_q.row;
                        s_d.timer    = TMR_W'(REF_CYC);
                    end
                    OP_RD, OP_WR: begin
                        pop = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (s_q.timer != '0) begin
            s_d.timer = s_q.timer - TMR_W'(1);
        end else if (rfsh_req) begin
            s_d.cmd_vld = 1'b1;
            s_d.col     = '0;
            s_d.tag     = '0;
            if (s_q.row_open) begin
                s_d.op  = OP_PRE;
                s_d.row = s_q.open_row;
            end else begin
                s_d.op  = OP_REF;
                s_d.row = rfsh_row;
            end
        end else if (q_cnt != '0) begin
            s_d.cmd_vld = 1'b1;
            s_d.idx     = tgt;
            s_d.col     = q_col[tgt];
            s_d.tag     = q_tag[tgt];
            if (s_q.row_open && s_q.open_row == q_row[tgt]) begin
                s_d.op  = q_wr[tgt] ? OP_WR : OP_RD;
                s_d.row = q_row[tgt];
            end else if (s_q.row_open) begin
                s_d.op  = OP_PRE;
                s_d.row = s_q.open_row;
            end else begin
                s_d.op  = OP_ACT;
                s_d.row = q_row[tgt];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_valid = s_q.cmd_vld;
    assign cmd_op    = s_q.op;
    assign cmd_row   = s_q.row;
    assign cmd_col   = s_q.col;
    assign cmd_tag   = s_q.tag;

endmodule

// File: rtl/rowfirst_sched_chk.sv
module rowfirst_sched_chk #(
    parameter int DEPTH   = 8,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int TAG_W   = 4,
    parameter int PRE_CYC = 3,
    parameter int ACT_CYC = 4,
    parameter int REF_CYC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col,
    input logic [TAG_W-1:0] cmd_tag
);

    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic             open_t;
    logic [ROW_W-1:0] open_row_t;
    logic [7:0]       since;
    logic [7:0]       gap_req;
    logic             seen;
    logic             acc, is_col;

    assign acc    = cmd_valid && cmd_ready;
    assign is_col = (cmd_op == 3'd3) || (cmd_op == 3'd4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0; open_t <= 1'b0; open_row_t <= '0;
            since <= '0; gap_req <= '0; seen <= 1'b0;
        end else begin
            occ <= occ + OCC_W'(req_valid && req_ready) - OCC_W'(acc && is_col);
            if (acc) begin
                seen  <= 1'b1;
                since <= '0;
                case (cmd_op)
                    3'd1: begin open_t <= 1'b1; open_row_t <= cmd_row; gap_req <= 8'(ACT_CYC); end
                    3'd2: begin open_t <= 1'b0; gap_req <= 8'(PRE_CYC); end
                    3'd5: begin open_t <= 1'b1; open_row_t <= cmd_row; gap_req <= 8'(REF_CYC); end
                    default: gap_req <= '0;
                endcase
            end else if (since != 8'hff) begin
                since <= since + 8'd1;
            end
        end
    end

    // R2
    ready_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (occ < OCC_W'(DEPTH)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
        $stable(cmd_row) && $stable(cmd_col) && $stable(cmd_tag)));

    // R3
    col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_col) |-> (open_t && cmd_row == open_row_t));

    // R5
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd5)) |-> !open_t);

    // R10
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen) |-> (since > gap_req));

endmodule

bind rowfirst_sched rowfirst_sched_chk #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .PRE_CYC(PRE_CYC), .ACT_CYC(ACT_CYC), .REF_CYC(REF_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_tag(cmd_tag)
);

// File: tb/rowfirst_sched_tb_top.sv
`timescale 1ns/1ps
module rowfirst_sched_tb_top;

    localparam int DEPTH = 4, ROW_W = 8, COL_W = 6, TAG_W = 4;
    localparam int AGE_CAP = 3, PRE_CYC = 2, ACT_CYC = 3, REF_CYC = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0, rfsh_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic rfsh_req = 1'b0, cmd_ready = 1'b1;
    logic req_ready, cmd_valid;
    logic [2:0] cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic [TAG_W-1:0] cmd_tag;

    rowfirst_sched #(
        .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
        .AGE_CAP(AGE_CAP), .PRE_CYC(PRE_CYC), .ACT_CYC(ACT_CYC), .REF_CYC(REF_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_tag(req_tag), .rfsh_req(rfsh_req), .rfsh_row(rfsh_row),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_tag(cmd_tag)
    );

    always #5 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0, nlog = 0;
    int log_op [256];
    int log_row[256];
    int log_col[256];
    int log_tag[256];
    int log_cyc[256];

    always @(posedge clk) cyc <= cyc + 1;

    // accepted commands, sampled mid-cycle before the accepting edge
    always @(negedge clk) begin
        if (cmd_valid && cmd_ready && nlog < 256) begin
            log_op[nlog]  = int'(cmd_op);
            log_row[nlog] = int'(cmd_row);
            log_col[nlog] = int'(cmd_col);
            log_tag[nlog] = int'(cmd_tag);
            log_cyc[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic wr, input int row, input int col, input int tag);
        bit done = 0;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_tag = TAG_W'(tag);
        while (!done) begin
            @(negedge clk);
            if (req_ready) done = 1;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk); #2;
        cmd_ready = v;
    endtask

    task automatic wait_log(input string req, input int n);
        int k = 0;
        while (nlog < n && k < 1000) begin
            @(negedge clk);
            k++;
        end
        chk(req, "command count reached", (nlog >= n) ? 1 : 0, 1);
    endtask

    task automatic quiet(input string req, input int n);
        repeat (12) @(negedge clk);
        chk(req, "no extra command", nlog, n);
    endtask

    task automatic exp_cmd(input string req, input int i, input int op, input int row, input int tag);
        chk(req, $sformatf("op of cmd %0d", i), log_op[i], op);
        chk(req, $sformatf("row of cmd %0d", i), log_row[i], row);
        if (op == 3 || op == 4) chk(req, $sformatf("tag of cmd %0d", i), log_tag[i], tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_basic();
        int b = nlog;
        push(1'b0, 5, 3, 1);
        wait_log("R3", b + 2);
        exp_cmd("R1", b, 1, 5, 0);
        exp_cmd("R3", b + 1, 3, 5, 1);
        chk("R3", "column of read", log_col[b + 1], 3);
        chk("R10", "activate to read gap", log_cyc[b + 1] - log_cyc[b], ACT_CYC + 2);
        quiet("R3", b + 2);
    endtask

    task automatic t_hit_first();
        int b = nlog;
        set_ready(1'b0);
        push(1'b0, 5, 0, 2);
        push(1'b0, 9, 0, 3);
        push(1'b0, 5, 1, 4);
        set_ready(1'b1);
        wait_log("R4", b + 5);
        exp_cmd("R4", b, 3, 5, 2);
        exp_cmd("R4", b + 1, 3, 5, 4);
        exp_cmd("R4", b + 2, 2, 5, 0);
        exp_cmd("R4", b + 3, 1, 9, 0);
        exp_cmd("R4", b + 4, 3, 9, 3);
        quiet("R4", b + 5);
    endtask

    task automatic t_oldest_miss();
        int b = nlog;
        set_ready(1'b0);
        push(1'b0, 7, 0, 5);
        push(1'b0, 8, 0, 6);
        push(1'b0, 7, 2, 7);
        set_ready(1'b1);
        wait_log("R5", b + 7);
        exp_cmd("R5", b, 2, 9, 0);
        exp_cmd("R5", b + 1, 1, 7, 0);
        exp_cmd("R5", b + 2, 3, 7, 5);
        exp_cmd("R5", b + 3, 3, 7, 7);
        exp_cmd("R5", b + 4, 2, 7, 0);
        exp_cmd("R5", b + 5, 1, 8, 0);
        exp_cmd("R5", b + 6, 3, 8, 6);
        chk("R10", "precharge to activate gap", log_cyc[b + 1] - log_cyc[b], PRE_CYC + 2);
        quiet("R5", b + 7);
    endtask

    task automatic t_write_read();
        int b = nlog;
        set_ready(1'b0);
        push(1'b0, 8, 1, 8);
        push(1'b1, 3, 2, 9);
        push(1'b0, 3, 2, 10);
        set_ready(1'b1);
        wait_log("R6", b + 5);
        exp_cmd("R6", b, 3, 8, 8);
        exp_cmd("R6", b + 1, 2, 8, 0);
        exp_cmd("R6", b + 2, 1, 3, 0);
        exp_cmd("R6", b + 3, 4, 3, 9);
        exp_cmd("R6", b + 4, 3, 3, 10);
        quiet("R6", b + 5);
    endtask

    task automatic t_full();
        int b = nlog;
        set_ready(1'b0);
        for (int i = 0; i < DEPTH; i++) push(1'b0, 3, i, 11 + i);
        @(negedge clk);
        chk("R2", "req_ready when full", int'(req_ready), 0);
        @(negedge clk);
        chk("R9", "held command valid", int'(cmd_valid), 1);
        chk("R9", "held command tag", int'(cmd_tag), 11);
        set_ready(1'b1);
        wait_log("R2", b + DEPTH);
        @(negedge clk);
        chk("R2", "req_ready after drain", int'(req_ready), 1);
        for (int i = 0; i < DEPTH; i++) exp_cmd("R4", b + i, 3, 3, 11 + i);
        quiet("R2", b + DEPTH);
    endtask

    task automatic t_refresh();
        int b = nlog;
        @(posedge clk); #2;
        rfsh_row = 8'd12; rfsh_req = 1'b1;
        wait_log("R8", b + 2);
        @(posedge clk); #2;
        rfsh_req = 1'b0;
        exp_cmd("R8", b, 2, 3, 0);
        exp_cmd("R8", b + 1, 5, 12, 0);
        push(1'b0, 12, 4, 15);
        wait_log("R8", b + 3);
        exp_cmd("R8", b + 2, 3, 12, 15);
        chk("R10", "refresh to read gap at least", (log_cyc[b + 2] - log_cyc[b + 1] >= REF_CYC + 2) ? 1 : 0, 1);
        quiet("R8", b + 3);
    endtask

    task automatic t_refresh_first();
        int b = nlog;
        @(posedge clk); #2;
        rfsh_row = 8'd20; rfsh_req = 1'b1;
        push(1'b0, 12, 5, 1);
        wait_log("R8", b + 2);
        @(posedge clk); #2;
        rfsh_req = 1'b0;
        wait_log("R8", b + 5);
        exp_cmd("R8", b, 2, 12, 0);
        exp_cmd("R8", b + 1, 5, 20, 0);
        exp_cmd("R8", b + 2, 2, 20, 0);
        exp_cmd("R8", b + 3, 1, 12, 0);
        exp_cmd("R8", b + 4, 3, 12, 1);
        chk("R10", "refresh to precharge gap", log_cyc[b + 2] - log_cyc[b + 1], REF_CYC + 2);
        quiet("R8", b + 5);
    endtask

    task automatic t_starve();
        int b = nlog;
        set_ready(1'b0);
        push(1'b0, 12, 0, 2);
        push(1'b0, 30, 0, 3);
        push(1'b0, 12, 1, 4);
        push(1'b0, 12, 2, 5);
        fork
            set_ready(1'b1);
            begin
                push(1'b0, 12, 3, 6);
                push(1'b0, 12, 4, 7);
            end
        join
        wait_log("R7", b + 10);
        exp_cmd("R7", b, 3, 12, 2);
        exp_cmd("R7", b + 1, 3, 12, 4);
        exp_cmd("R7", b + 2, 3, 12, 5);
        exp_cmd("R7", b + 3, 3, 12, 6);
        exp_cmd("R7", b + 4, 2, 12, 0);
        exp_cmd("R7", b + 5, 1, 30, 0);
        exp_cmd("R7", b + 6, 3, 30, 3);
        exp_cmd("R7", b + 7, 2, 30, 0);
        exp_cmd("R7", b + 8, 1, 12, 0);
        exp_cmd("R7", b + 9, 3, 12, 7);
        quiet("R7", b + 10);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_hit_first();
        t_oldest_miss();
        t_write_read();
        t_full();
        t_refresh();
        t_refresh_first();
        t_starve();
        summary();
        $finish;
    end

endmodule